// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Controller

This block is a small memory-mapped pulse-width modulator with up to two channels. A shared control word selects, for each channel, a clock divider from a fixed table, an active output level, a run enable and a counter gate. Each channel also has its own timing word. The upper half of that word holds the period length in prescaled ticks minus one. The lower half holds the number of ticks for which the output sits at its active level at the start of each period.

Software programs the timing word, picks a divider code and sets both the enable and the gate bits to start a channel. Timing words written while a channel is running are held back. They take effect only where one period ends and the next begins, so no period is ever cut short or stretched. A per-channel ready flag in the control word shows when such an update is still waiting.

Top module: `prescaled_pwm`

## Requirements
- R1: The control word is at byte address 0x0 and channel n's timing word is at 0x4 + 4*n. Each channel's control group starts at bit 15*n and holds the divider code in bits 3:0, enable in bit 4, active level in bit 5 and gate in bit 6. Bit 28+n is the read-only ready flag. All other control bits read 0. A timing word reads back as last written, and unmapped addresses read 0.
- R2: A channel runs only when its enable and gate bits are both 1. Otherwise its output sits at the inactive level, which is the inverse of its active-level bit. After reset both outputs are 1.
- R3: With active level 1 the output is high during the duty portion. With active level 0 it is low during the duty portion and high for the rest of the period.
- R4: A running channel's period lasts (timing[31:16] + 1) prescaled ticks. The output is active for the first timing[15:0] ticks of each period. Code 15 gives one tick per clock.
- R5: A duty count of 0 keeps the output inactive. A duty count at or above the period length keeps it active for the whole period.
- R6: Codes 0 to 4 give one tick every 120, 180, 240, 360 or 480 clocks. Codes 8 to 12 give one tick every 12000, 24000, 36000, 48000 or 72000 clocks.
- R7: Codes 5, 6, 7, 13 and 14 are reserved. A channel with a reserved code does not count, and its output stays at the inactive level.
- R8: A timing-word write to a running channel is held as pending, and that channel's ready flag reads 1. The value is applied at the next period boundary, where the flag clears and the new period starts.
- R9: A timing-word write to a channel that is not running is applied at once, and the ready flag stays 0.
- R10: Clearing the gate holds the divider and period counters at zero. Setting the gate again restarts the channel at the beginning of a period.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH (2) | One modulated output per channel |

## Verification
The assertions assume that accesses are word aligned and that a write strobe lasts a single clock with stable address and data. They also assume that the timing word's period half is not changed underneath a running counter except through the pending path. The stimulus drives every access from one task that raises the strobe for exactly one cycle at aligned addresses. Between write strobes it only changes the address, for reads, and it never drives reset in the middle of a scenario.

// File: rtl/pwm_pkg.sv
// Package: shared constants and the divider lookup for the prescaled PWM.
// Assumes a 32-bit register word and at most two channels, so that the
// ready flags at bit 28+n never overlap a channel's control group.
package pwm_pkg;

    localparam int unsigned PSC_W     = 17;  // wide enough for a divide of 72000
    localparam int unsigned CH_STRIDE = 15;  // bit distance between channel groups
    localparam int unsigned RDY_BASE  = 28;  // first ready-flag bit
    localparam int unsigned F_EN      = 4;
    localparam int unsigned F_ACT     = 5;
    localparam int unsigned F_GATE    = 6;

    // Divide ratio for a code; 0 marks a reserved code that yields no ticks.
    function automatic logic [PSC_W-1:0] psc_divide(input logic [3:0] code,
                                                    input bit bypass_ok);
        logic [PSC_W-1:0] d;
        case (code)
            4'd0:    d = 17'd120;
            4'd1:    d = 17'd180;
            4'd2:    d = 17'd240;
            4'd3:    d = 17'd360;
            4'd4:    d = 17'd480;
            4'd8:    d = 17'd12000;
            4'd9:    d = 17'd24000;
            4'd10:   d = 17'd36000;
            4'd11:   d = 17'd48000;
            4'd12:   d = 17'd72000;
            4'd15:   d = bypass_ok ? 17'd1 : 17'd0;
            default: d = 17'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Module: per-channel tick generator. It divides the reference clock by the
// ratio chosen through the divider code and emits a one-cycle tick.
// Assumes the code only changes while run is low (the counter is then held
// at zero), so a ratio change never lands mid-count.
module pwm_prescaler #(
    parameter bit HAS_BYPASS = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] code,
    output logic       valid,
    output logic       tick
);
    import pwm_pkg::*;

    logic [PSC_W-1:0] div;
    logic [PSC_W-1:0] cnt;

    // Decode the divide ratio and whether the code is usable.
    always_comb begin
        div   = psc_divide(code, HAS_BYPASS);
        valid = (div != '0);
        tick  = run && valid && (cnt == div - 1'b1);
    end

    // Clock counter, held at zero when stopped and wrapped on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || !valid || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
// Module: period counter and output shaper for one channel. It counts
// prescaled ticks from 0 to the period limit and drives the active level
// while the count is below the duty value.
// Assumes prd and duty change only at a boundary or while the channel is
// stopped, when the count is zero.
module pwm_channel #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic             tick,
    input  logic [CNT_W-1:0] prd,
    input  logic [CNT_W-1:0] duty,
    input  logic             act_lvl,
    output logic [CNT_W-1:0] pos,
    output logic             bnd,
    output logic             pwm
);
    logic in_duty;

    // Boundary detect and output level selection.
    always_comb begin
        bnd     = tick && (pos == prd);
        in_duty = live && (pos < duty);
        pwm     = in_duty ? act_lvl : !act_lvl;
    end

    // Position within the period, restarted at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (!live) begin
            pos <= '0;
        end else if (tick) begin
            pos <= (pos == prd) ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_regs.sv
// Module: register file for the PWM. It holds the shared control word, the
// pending and active timing words per channel and the ready flags, and
// serves combinational reads.
// Assumes word-aligned accesses; an access with address bits 1:0 set hits
// nothing. A write strobe lasts one clock.
module pwm_regs #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [NUM_CH-1:0]            live,
    input  logic [NUM_CH-1:0]            bnd,
    output logic [NUM_CH-1:0][3:0]       psc,
    output logic [NUM_CH-1:0]            en,
    output logic [NUM_CH-1:0]            act_lvl,
    output logic [NUM_CH-1:0]            gate,
    output logic [NUM_CH-1:0]            pend,
    output logic [NUM_CH-1:0][CNT_W-1:0] prd,
    output logic [NUM_CH-1:0][CNT_W-1:0] duty
);
    import pwm_pkg::*;

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]         idx;
    logic                     aligned;
    logic                     wr_ctrl;
    logic [NUM_CH-1:0]        wr_tm;
    logic [NUM_CH-1:0][31:0]  pend_word;
    logic [NUM_CH-1:0][31:0]  act_word;

    // Address decode into the control strobe and per-channel timing strobes.
    always_comb begin
        idx     = bus_addr[ADDR_W-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
        wr_ctrl = bus_we && aligned && (idx == '0);
        for (int n = 0; n < NUM_CH; n++) begin
            wr_tm[n] = bus_we && aligned && (idx == IDX_W'(n + 1));
        end
    end

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            // Control group of channel n inside the shared word.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    psc[n]     <= '0;
                    en[n]      <= 1'b0;
                    act_lvl[n] <= 1'b0;
                    gate[n]    <= 1'b0;
                end else if (wr_ctrl) begin
                    psc[n]     <= bus_wdata[CH_STRIDE*n +: 4];
                    en[n]      <= bus_wdata[CH_STRIDE*n + F_EN];
                    act_lvl[n] <= bus_wdata[CH_STRIDE*n + F_ACT];
                    gate[n]    <= bus_wdata[CH_STRIDE*n + F_GATE];
                end
            end

            // Timing word: direct load when stopped, deferred to the boundary when running.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_word[n] <= '0;
                    act_word[n]  <= '0;
                    pend[n]      <= 1'b0;
                end else if (wr_tm[n]) begin
                    pend_word[n] <= bus_wdata;
                    if (live[n]) begin
                        pend[n] <= 1'b1;
                    end else begin
                        act_word[n] <= bus_wdata;
                        pend[n]     <= 1'b0;
                    end
                end else if (pend[n] && (bnd[n] || !live[n])) begin
                    act_word[n] <= pend_word[n];
                    pend[n]     <= 1'b0;
                end
            end

            // Split the active word into period limit and duty count.
            always_comb begin
                prd[n]  = act_word[n][16 +: CNT_W];
                duty[n] = act_word[n][0 +: CNT_W];
            end
        end
    endgenerate

    // Read multiplexer; reserved bits and unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (aligned && idx == '0) begin
            for (int n = 0; n < NUM_CH; n++) begin
                bus_rdata[CH_STRIDE*n +: 4]      = psc[n];
                bus_rdata[CH_STRIDE*n + F_EN]    = en[n];
                bus_rdata[CH_STRIDE*n + F_ACT]   = act_lvl[n];
                bus_rdata[CH_STRIDE*n + F_GATE]  = gate[n];
                bus_rdata[RDY_BASE + n]          = pend[n];
            end
        end else if (aligned) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (idx == IDX_W'(n + 1)) begin
                    bus_rdata = pend_word[n];
                end
            end
        end
    end

endmodule

// File: rtl/prescaled_pwm.sv
// Module: top level of the prescaled PWM. It ties the register file to one
// tick generator and one period counter per channel.
// Assumes NUM_CH is 1 or 2 and CNT_W is at most 16.
module prescaled_pwm #(
    parameter int unsigned NUM_CH     = 2,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned ADDR_W     = 4,
    parameter bit          HAS_BYPASS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0][3:0]       psc_w;
    logic [NUM_CH-1:0]            en_w;
    logic [NUM_CH-1:0]            act_w;
    logic [NUM_CH-1:0]            gate_w;
    logic [NUM_CH-1:0]            pend_w;
    logic [NUM_CH-1:0][CNT_W-1:0] prd_w;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_w;
    logic [NUM_CH-1:0][CNT_W-1:0] pos_w;
    logic [NUM_CH-1:0]            run_w;
    logic [NUM_CH-1:0]            valid_w;
    logic [NUM_CH-1:0]            live_w;
    logic [NUM_CH-1:0]            tick_w;
    logic [NUM_CH-1:0]            bnd_w;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .live      (live_w),
        .bnd       (bnd_w),
        .psc       (psc_w),
        .en        (en_w),
        .act_lvl   (act_w),
        .gate      (gate_w),
        .pend      (pend_w),
        .prd       (prd_w),
        .duty      (duty_w)
    );

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
            // A channel counts only with enable, gate and a usable code.
            always_comb begin
                run_w[n]  = en_w[n] && gate_w[n];
                live_w[n] = run_w[n] && valid_w[n];
            end

            pwm_prescaler #(
                .HAS_BYPASS (HAS_BYPASS)
            ) i_psc (
                .clk   (clk),
                .rst_n (rst_n),
                .run   (run_w[n]),
                .code  (psc_w[n]),
                .valid (valid_w[n]),
                .tick  (tick_w[n])
            );

            pwm_channel #(
                .CNT_W (CNT_W)
            ) i_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .live    (live_w[n]),
                .tick    (tick_w[n]),
                .prd     (prd_w[n]),
                .duty    (duty_w[n]),
                .act_lvl (act_w[n]),
                .pos     (pos_w[n]),
                .bnd     (bnd_w[n]),
                .pwm     (pwm_out[n])
            );
        end
    endgenerate

endmodule

// File: rtl/pwm_checker.sv
// Module: property checker for the prescaled PWM, bound into the top level.
// Assumes word-aligned single-cycle writes, as the bench produces.
module pwm_checker #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_we,
    input logic [31:0]                  bus_rdata,
    input logic [NUM_CH-1:0]            live,
    input logic [NUM_CH-1:0]            gate,
    input logic [NUM_CH-1:0]            act_lvl,
    input logic [NUM_CH-1:0]            pend,
    input logic [NUM_CH-1:0]            bnd,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic [NUM_CH-1:0][CNT_W-1:0] pos,
    input logic [NUM_CH-1:0][CNT_W-1:0] prd,
    input logic [NUM_CH-1:0][CNT_W-1:0] duty
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    function automatic logic [31:0] ctrl_mask();
        logic [31:0] m = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            m = m | (32'h7F << (15 * n)) | (32'h1 << (28 + n));
        end
        return m;
    endfunction

    localparam logic [31:0] MASK = ctrl_mask();

    // R1: control reads never show reserved bits.
    assert_ctrl_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> ((bus_rdata & ~MASK) == 32'h0));

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_prop
            // R2: a stopped channel shows its inactive level.
            assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !live[n] |-> (pwm_out[n] == !act_lvl[n]));
            // R5: zero duty never reaches the active level.
            assert_duty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (duty[n] == '0) |-> (pwm_out[n] == !act_lvl[n]));
            // R5: a duty at or past the period length stays active while running.
            assert_duty_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (live[n] && (duty[n] > prd[n])) |-> (pwm_out[n] == act_lvl[n]));
            // R8: a pending update is consumed at the boundary it waits for.
            assert_ready_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[n] && bnd[n] && !(bus_we && bus_addr[ADDR_W-1:2] == IDX_W'(n + 1)))
                |=> !pend[n]);
            // R10: an open gate holds the period counter at its start.
            assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !gate[n] |=> (pos[n] == '0));
        end
    endgenerate

endmodule

bind prescaled_pwm pwm_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) i_pwm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .live      (live_w),
    .gate      (gate_w),
    .act_lvl   (act_w),
    .pend      (pend_w),
    .bnd       (bnd_w),
    .pwm_out   (pwm_out),
    .pos       (pos_w),
    .prd       (prd_w),
    .duty      (duty_w)
);

// File: tb/test_prescaled_pwm.sv
`timescale 1ns/1ps
module test_prescaled_pwm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    prescaled_pwm i_prescaled_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    // Control group for one channel: code, enable, active level, gate.
    function automatic logic [31:0] cfg(input int ch, input logic [3:0] code,
                                        input bit en, input bit act, input bit gt);
        logic [31:0] v;
        v = {25'b0, gt, act, en, code};
        return v << (15 * ch);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Count active-high samples on one output over n consecutive cycles.
    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch]) hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'h0, d);
        check("R1", "control after reset", d, 32'h0);
        check("R2", "outputs after reset", {30'b0, pwm_out}, 32'h3);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(4'h4, 32'h0003_0002);
        rd(4'h4, d);
        check("R1", "timing word ch0 readback", d, 32'h0003_0002);
        wr(4'h8, 32'h0005_0001);
        rd(4'h8, d);
        check("R1", "timing word ch1 readback", d, 32'h0005_0001);
        rd(4'hC, d);
        check("R1", "unmapped address", d, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d);
        check("R1", "control reserved bits", d, 32'h003F_807F);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_basic;
        int hi;
        wr(4'h4, 32'h0004_0002);
        wr(4'h0, cfg(0, 4'hF, 1, 1, 1));
        check("R4", "first sample active", {31'b0, pwm_out[0]}, 32'h1);
        count_high(0, 10, hi);
        check("R4", "active cycles over two periods", hi, 4);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_polarity;
        int hi;
        wr(4'h0, cfg(0, 4'hF, 1, 0, 1));
        count_high(0, 5, hi);
        check("R3", "inverted: high cycles per period", hi, 3);
        wr(4'h0, cfg(0, 4'hF, 0, 1, 1));
        count_high(0, 6, hi);
        check("R2", "enable clear, active level 1", hi, 0);
        wr(4'h0, cfg(0, 4'hF, 1, 1, 0));
        count_high(0, 6, hi);
        check("R2", "gate clear, active level 1", hi, 0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_edges;
        int hi;
        wr(4'h4, 32'h0003_0000);
        wr(4'h0, cfg(0, 4'hF, 1, 1, 1));
        count_high(0, 8, hi);
        check("R5", "zero duty", hi, 0);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0003_0009);
        wr(4'h0, cfg(0, 4'hF, 1, 1, 1));
        count_high(0, 8, hi);
        check("R5", "duty beyond period", hi, 8);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_prescale;
        int hi;
        wr(4'h4, 32'h0001_0001);
        wr(4'h0, cfg(0, 4'h0, 1, 1, 1));
        count_high(0, 120, hi);
        check("R6", "code 0 active half", hi, 120);
        count_high(0, 120, hi);
        check("R6", "code 0 idle half", hi, 0);
        wr(4'h0, 32'h0);
        wr(4'h0, cfg(0, 4'h1, 1, 1, 1));
        count_high(0, 180, hi);
        check("R6", "code 1 active half", hi, 180);
        count_high(0, 180, hi);
        check("R6", "code 1 idle half", hi, 0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_reserved;
        int hi;
        wr(4'h4, 32'h0003_0002);
        wr(4'h0, cfg(0, 4'h5, 1, 1, 1));
        count_high(0, 20, hi);
        check("R7", "code 5 output", hi, 0);
        wr(4'h0, cfg(0, 4'hD, 1, 1, 1));
        count_high(0, 20, hi);
        check("R7", "code 13 output", hi, 0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_reload;
        int hi;
        int waited;
        logic [31:0] d;
        wr(4'h4, 32'h0004_0001);
        wr(4'h0, cfg(0, 4'hF, 1, 1, 1));
        wr(4'h4, 32'h0004_0004);
        rd(4'h0, d);
        check("R8", "ready flag after running write", {31'b0, d[28]}, 32'h1);
        waited = 0;
        while (d[28] && waited < 20) begin
            @(negedge clk);
            rd(4'h0, d);
            waited++;
        end
        check("R8", "ready flag cleared at boundary", {31'b0, d[28]}, 32'h0);
        count_high(0, 5, hi);
        check("R8", "new duty after boundary", hi, 4);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_idle_load;
        int hi;
        logic [31:0] d;
        wr(4'h4, 32'h0002_0002);
        rd(4'h0, d);
        check("R9", "ready flag after idle write", {31'b0, d[28]}, 32'h0);
        wr(4'h0, cfg(0, 4'hF, 1, 1, 1));
        count_high(0, 3, hi);
        check("R9", "idle write in effect", hi, 2);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_gate_restart;
        int hi;
        wr(4'h4, 32'h0009_0003);
        wr(4'h0, cfg(0, 4'hF, 1, 1, 1));
        count_high(0, 5, hi);
        wr(4'h0, cfg(0, 4'hF, 1, 1, 0));
        wr(4'h0, cfg(0, 4'hF, 1, 1, 1));
        check("R10", "restart sample active", {31'b0, pwm_out[0]}, 32'h1);
        count_high(0, 10, hi);
        check("R10", "restart full period", hi, 3);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_second;
        int hi;
        wr(4'h8, 32'h0002_0001);
        wr(4'h0, cfg(1, 4'hF, 1, 1, 1));
        check("R2", "channel 0 idle beside channel 1", {31'b0, pwm_out[0]}, 32'h1);
        count_high(1, 6, hi);
        check("R4", "channel 1 at bit 15", hi, 2);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_polarity();
        t_edges();
        t_prescale();
        t_reserved();
        t_reload();
        t_idle_load();
        t_gate_restart();
        t_second();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule